// File: doc/BRIEF.md
# Interrupt and Status Register Unit

This block keeps the status byte, the interrupt-cause byte and the sequence-step value of a bus controller's register file, together with its first configuration byte. It drives one level-sensitive interrupt line. Other parts of the controller (the command decoder, the transfer engine) signal events through single-cycle strobes: they set cause bits, set or clear status flags, load a sequence step, raise or lower the interrupt, or report a bus-reset command. A host reads and writes the registers one byte at a time over a plain address/strobe port.

A host read of the cause register is the acknowledge path. The read returns the cause value as it stood before the access and, at the same clock edge, empties the cause register, drops the terminal-count status flag, moves the sequence step to the "command done" code and lowers the interrupt. Events that arrive in the same cycle as that read are merged after the clear, so none is lost. Whether a bus-reset command raises the interrupt is selected by one bit of the configuration byte. A soft-reset strobe returns every register to its reset value and deasserts the interrupt.

Top module: `irqsr_top`

## Requirements
- R1: After hard reset (rst_n low) the status (address 0), cause (address 1) and sequence-step (address 2) registers read 0x00, the configuration register (address 3) reads 0x07 and irq is low.
- R2: An ev_raise strobe sets the pending bit (status bit 7) and drives irq high from the next cycle; irq always equals status bit 7.
- R3: An ev_lower strobe clears the pending bit and irq from the next cycle; when ev_raise and ev_lower arrive in the same cycle the raise wins.
- R4: In a cycle with host_rd high at address 1, host_rdata shows the cause value held before the read, and the cause register is 0x00 from the next cycle when no cause event arrives in that cycle.
- R5: The same cause read clears the terminal-count flag (status bit 4), loads the sequence step with 4 and lowers irq, each from the next cycle.
- R6: Events arriving in the cycle of a cause read take precedence over its clearing: cause bits from ev_cause_set, status bits from ev_stat_set, a sequence value from ev_seq_vld/ev_seq and an ev_raise all take effect.
- R7: A bus_rst_cmd strobe replaces the cause register with 0x80 (merged with same-cycle ev_cause_set bits) and raises the interrupt only when configuration bit 6 is 0.
- R8: A soft_rst strobe returns all four registers to their R1 values and drives irq low from the next cycle, overriding every other input of that cycle.
- R9: A host write to address 3 stores the byte in the configuration register; writes to addresses 0, 1 and 2 change nothing, and reads of addresses 4 to 7 return 0x00.
- R10: ev_stat_set sets and ev_stat_clr clears status bits other than bit 7, a set winning over a clear of the same bit; neither strobe mask touches the pending bit or irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft-reset strobe |
| host_rd | input | 1 | Host read strobe (side effects at address 1) |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Register address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte of the addressed register, combinational |
| ev_raise | input | 1 | Raise-interrupt event strobe |
| ev_lower | input | 1 | Lower-interrupt event strobe |
| ev_cause_set | input | 8 | Cause bits to set |
| ev_stat_set | input | 8 | Status bits to set (bit 7 ignored) |
| ev_stat_clr | input | 8 | Status bits to clear (bit 7 ignored) |
| ev_seq_vld | input | 1 | Load the sequence step |
| ev_seq | input | 3 | Sequence step value to load |
| bus_rst_cmd | input | 1 | Bus-reset command strobe |
| irq | output | 1 | Level interrupt output |

## Verification
The bound checker watches on every cycle the single-edge consequences: a raise or unmasked bus reset sets irq, an isolated lower clears it, a cause read empties the register and lands the done step unless an event overrides it, same-cycle cause bits survive the read, and a soft reset restores the configuration byte. The ignored writes, the set-over-clear rule on status bits, the masking of the bus-reset interrupt by the configuration bit and the readback of unmapped addresses are visible only through the bench's scenarios and its per-cycle comparison against its reference model.

// File: rtl/irqsr_pkg.sv
package irqsr_pkg;
   typedef enum logic [1:0] {
      SEL_STAT  = 2'd0,
      SEL_CAUSE = 2'd1,
      SEL_SEQ   = 2'd2,
      SEL_CFG   = 2'd3
   } irqsr_sel_e;

   typedef struct packed {
      logic       hit;
      irqsr_sel_e sel;
   } irqsr_dec_t;
endpackage

// File: rtl/irqsr_status.sv
module irqsr_status #(
   parameter int DATA_W   = 8,
   parameter int PEND_BIT = 7,
   parameter int TC_BIT   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              raise,
   input  logic              lower,
   input  logic              cause_rd,
   input  logic [DATA_W-1:0] set_mask,
   input  logic [DATA_W-1:0] clr_mask,
   output logic [DATA_W-1:0] stat_q,
   output logic              irq
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      logic q;
      if (b == PEND_BIT) begin : g_pend
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                q <= 1'b0;
            else if (soft_rst)         q <= 1'b0;
            else if (raise)            q <= 1'b1;
            else if (lower || cause_rd) q <= 1'b0;
         end
      end else begin : g_flag
         logic ack_clr;
         assign ack_clr = (b == TC_BIT) ? cause_rd : 1'b0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          q <= 1'b0;
            else if (soft_rst)                   q <= 1'b0;
            else if (set_mask[b])                q <= 1'b1;
            else if (clr_mask[b] || ack_clr)     q <= 1'b0;
         end
      end
      assign stat_q[b] = q;
   end

   assign irq = stat_q[PEND_BIT];
endmodule

// File: rtl/irqsr_cause.sv
module irqsr_cause #(
   parameter int DATA_W     = 8,
   parameter int RST_CAUSE  = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              cause_rd,
   input  logic              bus_rst,
   input  logic [DATA_W-1:0] ev_set,
   output logic [DATA_W-1:0] cause_q
);
   logic [DATA_W-1:0] base;

   always_comb begin
      if (bus_rst)       base = DATA_W'(RST_CAUSE);
      else if (cause_rd) base = '0;
      else               base = cause_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cause_q <= '0;
      else if (soft_rst) cause_q <= '0;
      else               cause_q <= base | ev_set;
   end
endmodule

// File: rtl/irqsr_seqcfg.sv
module irqsr_seqcfg #(
   parameter int DATA_W   = 8,
   parameter int SEQ_W    = 3,
   parameter int SEQ_DONE = 4,
   parameter int CFG_RST  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              cause_rd,
   input  logic              seq_vld,
   input  logic [SEQ_W-1:0]  seq_in,
   input  logic              cfg_wr,
   input  logic [DATA_W-1:0] cfg_in,
   output logic [SEQ_W-1:0]  seq_q,
   output logic [DATA_W-1:0] cfg_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        seq_q <= '0;
      else if (soft_rst) seq_q <= '0;
      else if (seq_vld)  seq_q <= seq_in;
      else if (cause_rd) seq_q <= SEQ_W'(SEQ_DONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg_q <= DATA_W'(CFG_RST);
      else if (soft_rst) cfg_q <= DATA_W'(CFG_RST);
      else if (cfg_wr)   cfg_q <= cfg_in;
   end
endmodule

// File: rtl/irqsr_rdmux.sv
module irqsr_rdmux
   import irqsr_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int SEQ_W    = 3,
   parameter bit RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  irqsr_dec_t        dec,
   input  logic [DATA_W-1:0] stat_q,
   input  logic [DATA_W-1:0] cause_q,
   input  logic [SEQ_W-1:0]  seq_q,
   input  logic [DATA_W-1:0] cfg_q,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] sel_val;

   always_comb begin
      sel_val = '0;
      if (dec.hit) begin
         unique case (dec.sel)
            SEL_STAT:  sel_val = stat_q;
            SEL_CAUSE: sel_val = cause_q;
            SEL_SEQ:   sel_val = DATA_W'(seq_q);
            SEL_CFG:   sel_val = cfg_q;
         endcase
      end
   end

   if (RDATA_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= sel_val;
      end
   end else begin : g_comb
      assign rdata = sel_val;
   end
endmodule

// File: rtl/irqsr_top.sv
module irqsr_top
   import irqsr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 3,
   parameter int SEQ_W       = 3,
   parameter int PEND_BIT    = 7,
   parameter int TC_BIT      = 4,
   parameter int RST_CAUSE   = 8'h80,
   parameter int RPT_DIS_BIT = 6,
   parameter int SEQ_DONE    = 4,
   parameter int CFG_RST     = 7,
   parameter bit RDATA_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              ev_raise,
   input  logic              ev_lower,
   input  logic [DATA_W-1:0] ev_cause_set,
   input  logic [DATA_W-1:0] ev_stat_set,
   input  logic [DATA_W-1:0] ev_stat_clr,
   input  logic              ev_seq_vld,
   input  logic [SEQ_W-1:0]  ev_seq,
   input  logic              bus_rst_cmd,
   output logic              irq
);
   localparam int NREG = 4;

   if (DATA_W < 2 || PEND_BIT >= DATA_W || TC_BIT >= DATA_W || RPT_DIS_BIT >= DATA_W)
   begin : g_bad_bits
      $error("irqsr_top: bit position outside the data width");
   end
   if (PEND_BIT == TC_BIT) begin : g_bad_alias
      $error("irqsr_top: pending and terminal-count bits must differ");
   end
   if ((1 << ADDR_W) < NREG) begin : g_bad_addr
      $error("irqsr_top: address width too small for the register set");
   end
   if (SEQ_W > DATA_W || SEQ_DONE >= (1 << SEQ_W)) begin : g_bad_seq
      $error("irqsr_top: sequence step does not fit");
   end

   irqsr_dec_t        dec;
   logic              cause_rd;
   logic              cfg_wr;
   logic              raise_all;
   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] cause_q;
   logic [SEQ_W-1:0]  seq_q;
   logic [DATA_W-1:0] cfg_q;
   logic [DATA_W-1:0] set_mask;
   logic [DATA_W-1:0] clr_mask;

   always_comb begin
      dec.hit = (host_addr < ADDR_W'(NREG));
      dec.sel = irqsr_sel_e'(host_addr[1:0]);
   end

   assign cause_rd  = host_rd && dec.hit && (dec.sel == SEL_CAUSE);
   assign cfg_wr    = host_wr && dec.hit && (dec.sel == SEL_CFG);
   assign raise_all = ev_raise || (bus_rst_cmd && !cfg_q[RPT_DIS_BIT]);
   assign set_mask  = ev_stat_set & ~(DATA_W'(1) << PEND_BIT);
   assign clr_mask  = ev_stat_clr & ~(DATA_W'(1) << PEND_BIT);

   irqsr_status #(.DATA_W(DATA_W), .PEND_BIT(PEND_BIT), .TC_BIT(TC_BIT)) u_status (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .raise(raise_all),
      .lower(ev_lower), .cause_rd(cause_rd), .set_mask(set_mask),
      .clr_mask(clr_mask), .stat_q(stat_q), .irq(irq)
   );

   irqsr_cause #(.DATA_W(DATA_W), .RST_CAUSE(RST_CAUSE)) u_cause (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cause_rd(cause_rd),
      .bus_rst(bus_rst_cmd), .ev_set(ev_cause_set), .cause_q(cause_q)
   );

   irqsr_seqcfg #(.DATA_W(DATA_W), .SEQ_W(SEQ_W), .SEQ_DONE(SEQ_DONE), .CFG_RST(CFG_RST)) u_seqcfg (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cause_rd(cause_rd),
      .seq_vld(ev_seq_vld), .seq_in(ev_seq), .cfg_wr(cfg_wr), .cfg_in(host_wdata),
      .seq_q(seq_q), .cfg_q(cfg_q)
   );

   irqsr_rdmux #(.DATA_W(DATA_W), .SEQ_W(SEQ_W), .RDATA_REG(RDATA_REG)) u_rdmux (
      .clk(clk), .rst_n(rst_n), .dec(dec), .stat_q(stat_q), .cause_q(cause_q),
      .seq_q(seq_q), .cfg_q(cfg_q), .rdata(host_rdata)
   );
endmodule

// File: rtl/irqsr_chk.sv
module irqsr_chk #(
   parameter int DATA_W      = 8,
   parameter int SEQ_W       = 3,
   parameter int RST_CAUSE   = 8'h80,
   parameter int RPT_DIS_BIT = 6,
   parameter int SEQ_DONE    = 4,
   parameter int CFG_RST     = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              ev_raise,
   input logic              ev_lower,
   input logic              bus_rst_cmd,
   input logic [DATA_W-1:0] ev_cause_set,
   input logic              ev_seq_vld,
   input logic              cause_rd,
   input logic              irq,
   input logic [DATA_W-1:0] cause_q,
   input logic [SEQ_W-1:0]  seq_q,
   input logic [DATA_W-1:0] cfg_q
);
   p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_raise && !soft_rst) |=> irq);

   p_lower_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_lower && !ev_raise && !bus_rst_cmd) |=> !irq);

   p_rdclr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_rd && !soft_rst && ev_cause_set == '0 && !bus_rst_cmd) |=> (cause_q == '0));

   p_seqdone_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_rd && !soft_rst && !ev_seq_vld) |=> (seq_q == SEQ_W'(SEQ_DONE)));

   p_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_rd && !soft_rst) |=> ((cause_q & $past(ev_cause_set)) == $past(ev_cause_set)));

   p_busrst_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rst_cmd && !soft_rst) |=> ((cause_q & DATA_W'(RST_CAUSE)) == DATA_W'(RST_CAUSE)));

   p_busirq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rst_cmd && !soft_rst && !cfg_q[RPT_DIS_BIT]) |=> irq);

   p_soft_r8: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!irq && cfg_q == DATA_W'(CFG_RST) && cause_q == '0));
endmodule

bind irqsr_top irqsr_chk #(
   .DATA_W(DATA_W), .SEQ_W(SEQ_W), .RST_CAUSE(RST_CAUSE),
   .RPT_DIS_BIT(RPT_DIS_BIT), .SEQ_DONE(SEQ_DONE), .CFG_RST(CFG_RST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ev_raise(ev_raise),
   .ev_lower(ev_lower), .bus_rst_cmd(bus_rst_cmd), .ev_cause_set(ev_cause_set),
   .ev_seq_vld(ev_seq_vld), .cause_rd(cause_rd), .irq(irq), .cause_q(cause_q),
   .seq_q(seq_q), .cfg_q(cfg_q)
);

// File: tb/test_irqsr_top.sv
`timescale 1ns/1ps
module test_irqsr_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       host_rd = 1'b0;
   logic       host_wr = 1'b0;
   logic [2:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       ev_raise = 1'b0;
   logic       ev_lower = 1'b0;
   logic [7:0] ev_cause_set = '0;
   logic [7:0] ev_stat_set = '0;
   logic [7:0] ev_stat_clr = '0;
   logic       ev_seq_vld = 1'b0;
   logic [2:0] ev_seq = '0;
   logic       bus_rst_cmd = 1'b0;
   logic       irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   bit cmp_on = 1'b0;

   // reference model state
   logic [7:0] m_stat = 8'h00;
   logic [7:0] m_cause = 8'h00;
   logic [2:0] m_seq = 3'd0;
   logic [7:0] m_cfg = 8'h07;

   always #2 clk = ~clk;

   irqsr_top i_irqsr_top (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .host_rd(host_rd),
      .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .ev_raise(ev_raise), .ev_lower(ev_lower),
      .ev_cause_set(ev_cause_set), .ev_stat_set(ev_stat_set),
      .ev_stat_clr(ev_stat_clr), .ev_seq_vld(ev_seq_vld), .ev_seq(ev_seq),
      .bus_rst_cmd(bus_rst_cmd), .irq(irq)
   );

   always @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         m_stat = 8'h00; m_cause = 8'h00; m_seq = 3'd0; m_cfg = 8'h07;
      end else begin
         bit rdc;
         bit up;
         logic [7:0] s;
         rdc = host_rd && host_addr == 3'd1;
         up  = ev_raise || (bus_rst_cmd && !m_cfg[6]);
         s = m_stat & 8'h7F & ~ev_stat_clr;
         if (rdc) s[4] = 1'b0;
         s = s | (ev_stat_set & 8'h7F);
         if (up) s[7] = 1'b1;
         else if (ev_lower || rdc) s[7] = 1'b0;
         else s[7] = m_stat[7];
         m_stat = s;
         if (bus_rst_cmd) m_cause = 8'h80;
         else if (rdc) m_cause = 8'h00;
         m_cause = m_cause | ev_cause_set;
         if (ev_seq_vld) m_seq = ev_seq;
         else if (rdc) m_seq = 3'd4;
         if (host_wr && host_addr == 3'd3) m_cfg = host_wdata;
      end
   end

   function automatic logic [7:0] m_read(logic [2:0] a);
      case (a)
         3'd0: return m_stat;
         3'd1: return m_cause;
         3'd2: return {5'd0, m_seq};
         3'd3: return m_cfg;
         default: return 8'h00;
      endcase
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && cmp_on && !done) begin
         chk("R2 irq mirrors model", {7'd0, irq}, {7'd0, m_stat[7]});
         chk("R9 readback vs model", host_rdata, m_read(host_addr));
      end
   end

   task automatic idle();
      soft_rst = 0; host_rd = 0; host_wr = 0; ev_raise = 0; ev_lower = 0;
      ev_cause_set = 0; ev_stat_set = 0; ev_stat_clr = 0; ev_seq_vld = 0;
      ev_seq = 0; bus_rst_cmd = 0;
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   // apply currently driven inputs for one edge, then go idle
   task automatic apply();
      tick(); idle();
   endtask

   task automatic peek(logic [2:0] a, logic [7:0] exp, string tag);
      host_addr = a;
      @(negedge clk);
      chk(tag, host_rdata, exp);
   endtask

   task automatic irq_is(bit exp, string tag);
      @(negedge clk);
      chk(tag, {7'd0, irq}, {7'd0, exp});
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         bad++; total++;
         $display("FAIL watchdog: got 0 expected 1 (run finished)");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      idle();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      cmp_on = 1'b1;
      // R1 reset values
      peek(0, 8'h00, "R1 status reset");
      peek(1, 8'h00, "R1 cause reset");
      peek(2, 8'h00, "R1 seq reset");
      peek(3, 8'h07, "R1 cfg reset");
      irq_is(0, "R1 irq reset");

      // R2 raise
      tick(); ev_raise = 1; apply();
      irq_is(1, "R2 irq after raise");
      peek(0, 8'h80, "R2 pending bit");

      // R3 lower, and raise wins over lower
      tick(); ev_lower = 1; apply();
      irq_is(0, "R3 irq after lower");
      tick(); ev_raise = 1; ev_lower = 1; apply();
      irq_is(1, "R3 raise beats lower");

      // R4/R5 cause read
      tick(); ev_cause_set = 8'h18; ev_stat_set = 8'h10; ev_seq_vld = 1; ev_seq = 3'd1; apply();
      peek(0, 8'h90, "R10 TC set with pending");
      tick(); host_addr = 3'd1; host_rd = 1;
      @(negedge clk);
      chk("R4 read returns pre-read cause", host_rdata, 8'h18);
      tick(); idle();
      peek(1, 8'h00, "R4 cause cleared");
      peek(0, 8'h00, "R5 TC and pending cleared");
      peek(2, 8'h04, "R5 seq done code");
      irq_is(0, "R5 irq lowered");

      // R6 events during the read win
      tick(); host_addr = 3'd1; host_rd = 1; ev_cause_set = 8'h04; ev_raise = 1;
      ev_seq_vld = 1; ev_seq = 3'd2; ev_stat_set = 8'h10; apply();
      peek(1, 8'h04, "R6 cause bit kept");
      peek(2, 8'h02, "R6 seq load wins");
      peek(0, 8'h90, "R6 TC and pending kept");
      irq_is(1, "R6 raise wins");
      tick(); host_addr = 3'd1; host_rd = 1; apply();

      // R7 bus reset reporting
      tick(); ev_cause_set = 8'h02; apply();
      tick(); bus_rst_cmd = 1; ev_cause_set = 8'h01; apply();
      peek(1, 8'h81, "R7 reset cause replaces old bits");
      irq_is(1, "R7 irq with report enabled");
      tick(); host_addr = 3'd1; host_rd = 1; apply();
      tick(); host_addr = 3'd3; host_wr = 1; host_wdata = 8'h47; apply();
      peek(3, 8'h47, "R9 cfg write stored");
      tick(); bus_rst_cmd = 1; apply();
      peek(1, 8'h80, "R7 masked reset cause");
      irq_is(0, "R7 irq masked by cfg bit 6");

      // R9 read-only writes ignored, unmapped reads
      for (int a = 0; a < 3; a++) begin
         tick(); host_addr = 3'(a); host_wr = 1; host_wdata = 8'hFF; apply();
      end
      peek(0, 8'h00, "R9 status write ignored");
      peek(1, 8'h80, "R9 cause write ignored");
      peek(2, 8'h04, "R9 seq write ignored");
      peek(5, 8'h00, "R9 unmapped read zero");

      // R10 set/clear masks
      tick(); ev_stat_set = 8'h8F; apply();
      peek(0, 8'h0F, "R10 set masks skip pending");
      irq_is(0, "R10 irq untouched by set");
      tick(); ev_stat_clr = 8'h03; ev_stat_set = 8'h01; apply();
      peek(0, 8'h0D, "R10 set wins over clear");
      tick(); ev_raise = 1; apply();
      tick(); ev_stat_clr = 8'h80; apply();
      irq_is(1, "R10 irq untouched by clear");

      // R8 soft reset overrides
      tick(); soft_rst = 1; ev_raise = 1; ev_cause_set = 8'h11;
      host_addr = 3'd3; host_wr = 1; host_wdata = 8'h00; apply();
      irq_is(0, "R8 irq low after soft reset");
      peek(3, 8'h07, "R8 cfg restored");
      peek(1, 8'h00, "R8 cause cleared");
      peek(0, 8'h00, "R8 status cleared");

      // random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         tick();
         host_addr    = 3'($urandom_range(0, 7));
         host_rd      = ($urandom_range(0, 3) == 0);
         host_wr      = ($urandom_range(0, 7) == 0);
         host_wdata   = 8'($urandom);
         ev_raise     = ($urandom_range(0, 7) == 0);
         ev_lower     = ($urandom_range(0, 7) == 0);
         ev_cause_set = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00;
         ev_stat_set  = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00;
         ev_stat_clr  = ($urandom_range(0, 5) == 0) ? 8'($urandom) : 8'h00;
         ev_seq_vld   = ($urandom_range(0, 7) == 0);
         ev_seq       = 3'($urandom);
         bus_rst_cmd  = ($urandom_range(0, 15) == 0);
         soft_rst     = ($urandom_range(0, 63) == 0);
      end
      tick(); idle();
      repeat (2) @(posedge clk);
      @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule